// File: doc/BRIEF.md
# Ethernet Receive Frame Extractor (MII / RMII)

This block sits between an Ethernet PHY receive interface and the rest of a MAC receive path. It takes line symbols from the PHY, either 4-bit nibbles (MII) or 2-bit dibits (RMII), and gathers them into bytes. It finds the start-of-frame delimiter, drops the preamble, and computes the Ethernet CRC-32 over the frame. It holds back the trailing frame check sequence, so the downstream logic sees only the frame body: destination address through payload.

Each forwarded byte is a single-cycle pulse on `out_valid`. The final byte of a frame also carries `out_last` together with a CRC-error flag and an alignment-error flag. A qualifier input, `sym_en`, marks the clock cycles on which the PHY symbol is valid. MII and RMII 100 Mb/s tie it high. RMII 10 Mb/s pulses it once every ten cycles of the 50 MHz clock.

Reception is gated by `rx_en`. When it is raised while a frame is already on the wire, that whole frame is skipped, and reception begins with the next frame after the line goes idle.

Top module: `eth_rx_framer`

## Requirements
- R1: With `rmii_mode`=0, each byte is formed from two nibbles on `rx_d[3:0]`. The first nibble becomes bits 3:0 and the second becomes bits 7:4.
- R2: With `rmii_mode`=1, each byte is formed from four dibits on `rx_d[1:0]`, least significant dibit first. `rx_d[3:2]` is ignored.
- R3: Forwarding starts with the first byte that follows the symbol on which the last 8 received bits read 0xD5 (preamble bytes are 0x55). A frame in which that pattern never appears forwards nothing.
- R4: The last four bytes of every frame (the FCS) are never forwarded. A frame with four or fewer bytes after the delimiter forwards nothing.
- R5: The final forwarded byte of a frame has `out_last`=1 and every other forwarded byte has `out_last`=0. `out_last` is only ever high with `out_valid`, and is never followed directly by another valid byte.
- R6: On the last byte, `out_crc_err`=1 exactly when the frame fails the check. The check is a reflected CRC-32, polynomial 0x04C11DB7, register preset to all ones, run over the body and FCS. The FCS is the complemented CRC, sent low byte first.
- R7: On the last byte, `out_align_err`=1 exactly when the frame ended with an incomplete byte: an odd nibble in MII, or 1 to 3 spare dibits in RMII.
- R8: Symbols, `rx_dv` and frame ends are taken only on cycles with `sym_en`=1. With `sym_en` high one cycle in ten, the forwarded bytes are the same as at full rate.
- R9: While `rx_en`=0 nothing is forwarded. A frame already in progress when `rx_en` rises is dropped in full, and the next frame is received normally.
- R10: After reset every output is 0. Each received body byte produces exactly one single-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (25/2.5 MHz MII, 50 MHz RMII) |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable |
| rmii_mode | input | 1 | 0: 4-bit MII symbols, 1: 2-bit RMII symbols |
| sym_en | input | 1 | Symbol qualifier; high on cycles carrying a symbol |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_d | input | 4 | Receive symbol; RMII uses bits 1:0 |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Final byte of the frame |
| out_crc_err | output | 1 | CRC check failed (valid with out_last) |
| out_align_err | output | 1 | Frame ended mid-byte (valid with out_last) |

## Verification
The embedded assertions check the cycle-level rules on every clock edge. The end flags only appear with `out_last`, and `out_last` only with `out_valid`, and a frame end is never directly followed by a byte. Outputs move only after a qualified symbol, the state holds while `sym_en` is low, and disabling or an in-progress frame keeps the block waiting. The bench scenarios are the only way to show the rest. Byte assembly order in both modes, delimiter detection, FCS removal, runt suppression and the CRC and alignment verdicts all need whole frames. Dropping a frame caught at enable and 10 Mb/s RMII pacing are also covered by scenarios, checked against a reference computed from the frame contents.

// File: rtl/eth_rx_framer.sv
module eth_rx_framer #(
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rmii_mode,
  input  logic       sym_en,
  input  logic       rx_dv,
  input  logic [3:0] rx_d,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_crc_err,
  output logic       out_align_err
);
  localparam int DEPTH = FCS_BYTES + 1;
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);
  localparam logic [31:0] GOOD_RESIDUE = 32'hDEBB20E3;
  localparam logic [7:0] SFD = 8'hD5;

  typedef enum logic [1:0] {S_WAIT, S_HUNT, S_DATA} st_t;
  st_t st;

  logic [7:0]    sr;
  logic [1:0]    cnt;
  logic [31:0]   crc;
  logic [7:0]    dl [DEPTH];
  logic [FW-1:0] fill;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire [7:0]  sr_nx     = rmii_mode ? {rx_d[1:0], sr[7:2]} : {rx_d, sr[7:4]};
  wire        byte_done = (cnt == (rmii_mode ? 2'd3 : 2'd1));
  wire [31:0] crc_nx    = crc_byte(crc, sr_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      sr <= '0;
      cnt <= '0;
      crc <= '1;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) dl[i] <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_last <= 1'b0;
      out_crc_err <= 1'b0;
      out_align_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last <= 1'b0;
      out_crc_err <= 1'b0;
      out_align_err <= 1'b0;
      if (!rx_en) begin
        st <= S_WAIT;
        fill <= '0;
        cnt <= '0;
        sr <= '0;
      end else if (sym_en) begin
        if (!rx_dv) begin
          if (st == S_DATA && fill == FULL) begin
            out_valid <= 1'b1;
            out_data <= dl[DEPTH-1];
            out_last <= 1'b1;
            out_crc_err <= (crc != GOOD_RESIDUE);
            out_align_err <= (cnt != 2'd0);
          end
          st <= S_HUNT;
          sr <= '0;
          cnt <= '0;
          fill <= '0;
        end else begin
          sr <= sr_nx;
          case (st)
            S_HUNT: if (sr_nx == SFD) begin
              st <= S_DATA;
              cnt <= '0;
              crc <= '1;
              fill <= '0;
            end
            S_DATA: if (byte_done) begin
              cnt <= '0;
              crc <= crc_nx;
              dl[0] <= sr_nx;
              for (int i = 1; i < DEPTH; i++) dl[i] <= dl[i-1];
              if (fill == FULL) begin
                out_valid <= 1'b1;
                out_data <= dl[DEPTH-1];
              end else begin
                fill <= fill + 1'b1;
              end
            end else begin
              cnt <= cnt + 2'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R5
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R6 R7
  flags_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_crc_err || out_align_err) |-> out_last);
  // R3
  valid_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(st == S_DATA));
  // R8
  valid_after_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sym_en));
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !sym_en) |=> $stable(st));
  // R9
  disabled_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == S_WAIT));
  // R9
  skip_busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rx_dv) |=> (st == S_WAIT));
endmodule

// File: tb/eth_rx_framer_tb_top.sv
module eth_rx_framer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rmii_mode = 1'b0, sym_en = 1'b0, rx_dv = 1'b0;
  logic [3:0] rx_d = '0;
  logic out_valid, out_last, out_crc_err, out_align_err;
  logic [7:0] out_data;

  int checks = 0, errors = 0, per = 1, cyc = 0;
  logic [7:0] got[$];
  bit glast[$], gcrc[$], gal[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_framer dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rmii_mode(rmii_mode),
    .sym_en(sym_en), .rx_dv(rx_dv), .rx_d(rx_d), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_crc_err(out_crc_err), .out_align_err(out_align_err));

  always @(negedge clk) if (rst_n && out_valid) begin
    got.push_back(out_data); glast.push_back(out_last);
    gcrc.push_back(out_crc_err); gal.push_back(out_align_err);
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp < 190000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc32(input logic [7:0] q[$]);
    logic [31:0] c = '1;
    foreach (q[k]) for (int i = 0; i < 8; i++)
      c = (c[0] ^ q[k][i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic sym(input logic [3:0] s, input logic dv);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      sym_en = (i == 0); rx_dv = dv; rx_d = s;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    if (rmii_mode) for (int k = 0; k < 4; k++) sym({2'b11, b[2*k +: 2]}, 1'b1);
    else begin sym(b[3:0], 1'b1); sym(b[7:4], 1'b1); end
  endtask

  // kind: 0 normal, 1 no delimiter, 2 enable raised mid-frame
  task automatic run_frame(input bit rm, input int p, input int n, input bit corrupt,
                           input bit odd, input int kind);
    logic [7:0] body[$], wire_q[$];
    logic [31:0] fcs;
    string rq;
    rmii_mode = rm; per = p;
    for (int i = 0; i < n; i++) body.push_back(kind == 1 ? 8'hAA : 8'($urandom));
    fcs = ~crc32(body);
    if (corrupt) fcs[3] = ~fcs[3];
    for (int i = 0; i < 7; i++) wire_q.push_back(8'h55);
    wire_q.push_back(kind == 1 ? 8'hAA : 8'hD5);
    foreach (body[i]) wire_q.push_back(body[i]);
    for (int i = 0; i < 4; i++) wire_q.push_back(fcs[8*i +: 8]);
    got.delete(); glast.delete(); gcrc.delete(); gal.delete();
    if (kind == 2) rx_en = 1'b0;
    foreach (wire_q[i]) begin
      if (kind == 2 && i == 10) rx_en = 1'b1;
      send_byte(wire_q[i]);
    end
    if (odd) sym(4'h3, 1'b1);
    for (int i = 0; i < 4; i++) sym(4'h0, 1'b0);
    rq = (p > 1) ? "R8" : (rm ? "R2" : "R1");
    if (kind != 0 || n == 0) begin
      // R3 R4 R9: nothing forwarded
      chk(got.size() == 0, kind == 1 ? "R3" : (kind == 2 ? "R9" : "R4"), got.size(), 0);
    end else begin
      // R10: one pulse per body byte; R4: FCS not forwarded
      chk(got.size() == n, "R10", got.size(), n);
      if (got.size() == n) begin
        foreach (body[i]) begin
          chk(got[i] == body[i], rq, got[i], body[i]);
          chk(glast[i] == (i == n-1), "R5", glast[i], i == n-1);
        end
        chk(gcrc[n-1] == corrupt, "R6", gcrc[n-1], corrupt);
        chk(gal[n-1] == odd, "R7", gal[n-1], odd);
      end
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1BAD5EED);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk({out_valid, out_last, out_crc_err, out_align_err, out_data} == 0, "R10",
        {out_valid, out_last, out_crc_err, out_align_err, out_data}, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    for (int i = 0; i < 3; i++) sym(4'h0, 1'b0);
    run_frame(0, 1, 20, 0, 0, 0);   // R1
    run_frame(1, 1, 17, 0, 0, 0);   // R2
    run_frame(1, 10, 8, 0, 0, 0);   // R8
    run_frame(0, 1, 12, 1, 0, 0);   // R6
    run_frame(0, 1, 9, 0, 1, 0);    // R7
    run_frame(1, 1, 9, 0, 1, 0);    // R7 rmii
    run_frame(0, 1, 10, 0, 0, 1);   // R3
    run_frame(1, 1, 0, 0, 0, 0);    // R4 runt
    run_frame(0, 1, 1, 0, 0, 0);    // R4 single byte body
    run_frame(0, 1, 15, 0, 0, 2);   // R9
    run_frame(0, 1, 6, 0, 0, 0);    // R9 next frame received
    for (int f = 0; f < 30; f++) begin
      bit rm = 1'($urandom);
      int p = (rm && ($urandom % 3 == 0)) ? 10 : 1;
      run_frame(rm, p, 1 + ($urandom % (p > 1 ? 12 : 40)),
                ($urandom % 4) == 0, ($urandom % 4) == 0, 0);
    end
    summary();
  end
endmodule